// File: doc/BRIEF.md
# Oscillator and PLL Warm-up Timer

This block keeps the system clock away from the CPU until an oscillator or a frequency multiplier has had time to settle after it is switched on. It counts ticks of one of two count sources: the fast oscillator or the 32.768 kHz slow oscillator. A three-bit length code together with the source select sets the length of the wait. Software can start a wait with a start strobe. A wake-up event out of a low-power mode starts one on its own. When the count completes, a one-cycle release pulse lets the downstream clock gate pass the clock, and a sticky done flag records completion for polling.

The block runs on a single system clock. Each count source reaches it as a one-cycle tick strobe already synchronised to that clock. The source select and length code are captured when a wait begins and are held for the whole count. Length code 000 skips the wait and releases at once.

Top module: `warmup_timer`

## Requirements
- R1: After synchronous reset, `busy`, `done` and `release_pulse` are all 0.
- R2: With `src_sel`=0 (fast source), length codes 1 to 7 release after exactly 2^(9+code) fast ticks counted from the start, that is 2^10 up to 2^16. `busy` stays 1 until the release.
- R3: With `src_sel`=1 (slow source), codes 1 to 3 release after 2^(5+code) slow ticks (64, 128, 256). Codes 4 to 7 release after 2^(11+code) slow ticks (2^15 to 2^18).
- R4: Length code 000 needs no ticks. `release_pulse` and `done` are 1 in the cycle after the start, and `busy` is never asserted.
- R5: A high `wake_evt` while idle starts a wait in the same way as `start_wr`.
- R6: `start_wr` or `wake_evt` while `busy` is 1 is ignored. The running count and its completion point are unchanged.
- R7: Changes to `src_sel` or `len_code` while `busy` is 1 have no effect on the running wait.
- R8: `release_pulse` is high for exactly one cycle at completion, in the same cycle that `done` first reads 1 and `busy` reads 0.
- R9: `done` stays 1 until the next accepted start, which clears it in the following cycle. `busy` and `done` are never both 1.
- R10: Only ticks of the selected source advance the count. Ticks of the other source are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 1 | Count source: 0 fast oscillator, 1 slow oscillator |
| len_code | input | 3 | Wait length code, 000 = no wait |
| start_wr | input | 1 | Software start strobe |
| wake_evt | input | 1 | Wake-up from low power, starts a wait |
| hs_tick | input | 1 | One-cycle strobe per fast oscillator period |
| ls_tick | input | 1 | One-cycle strobe per slow oscillator period |
| busy | output | 1 | Wait in progress |
| done | output | 1 | Sticky completion flag |
| release_pulse | output | 1 | One-cycle clock release at completion |

## Verification
The hardest case to reach from the ports is a wait that hits its terminal count while the inputs keep moving. A new start, a swapped source or a rewritten code landing in the same cycles as the final tick would expose any path that re-reads live configuration or restarts the counter. The stimulus keeps sparse random ticks on both sources across the full length of fast and slow waits. Some runs also toggle the select, code and both start inputs at random on every cycle. The delivered ticks of the selected source are counted and compared with the exact power of two expected at the release.

// File: rtl/wu_pkg.sv
package wu_pkg;

    typedef struct packed {
        logic       sel;
        logic [2:0] code;
    } wu_cfg_t;

    typedef enum logic [0:0] {
        WU_IDLE = 1'b0,
        WU_RUN  = 1'b1
    } wu_state_e;

    // Exponent of the tick count for a configuration (code 0 unused).
    function automatic logic [4:0] wu_exp(wu_cfg_t c);
        logic [4:0] e;
        if (!c.sel)
            e = 5'd9 + {2'b00, c.code};
        else if (!c.code[2])
            e = 5'd5 + {2'b00, c.code};
        else
            e = 5'd11 + {2'b00, c.code};
        return e;
    endfunction

    function automatic logic wu_is_zero(wu_cfg_t c);
        return c.code == 3'd0;
    endfunction

endpackage

// File: rtl/wu_cfg_hold.sv
module wu_cfg_hold
    import wu_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  logic    busy,
    input  wu_cfg_t cfg_in,
    output wu_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (load)
            cfg_q <= cfg_in;
    end

    // R7: captured configuration does not move during a running wait
    p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));
endmodule

// File: rtl/wu_tick_sel.sv
module wu_tick_sel
    import wu_pkg::*;
(
    input  wu_cfg_t cfg,
    input  logic    hs_tick,
    input  logic    ls_tick,
    output logic    tick
);
    always_comb tick = cfg.sel ? ls_tick : hs_tick;
endmodule

// File: rtl/wu_counter.sv
module wu_counter
    import wu_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    en,
    input  wu_cfg_t cfg,
    output logic    hit
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term;

    always_comb begin
        term = (ONE << wu_exp(cfg)) - ONE;
        hit  = en && (cnt == term);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (en && !hit)
            cnt <= cnt + ONE;
    end

    // R10: without an enabled tick the count holds
    p_cnt_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt));
endmodule

// File: rtl/warmup_timer.sv
module warmup_timer
    import wu_pkg::*;
#(
    parameter int CNT_W = 18
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       src_sel,
    input  logic [2:0] len_code,
    input  logic       start_wr,
    input  logic       wake_evt,
    input  logic       hs_tick,
    input  logic       ls_tick,
    output logic       busy,
    output logic       done,
    output logic       release_pulse
);
    wu_state_e state;
    wu_cfg_t   cfg_in, cfg_q;
    logic      start_req, go, go_zero, tick, hit;

    always_comb begin
        cfg_in    = '{sel: src_sel, code: len_code};
        start_req = start_wr || wake_evt;
        go        = start_req && (state == WU_IDLE);
        go_zero   = go && wu_is_zero(cfg_in);
    end

    wu_cfg_hold u_cfg (
        .clk(clk), .rst(rst), .load(go), .busy(busy),
        .cfg_in(cfg_in), .cfg_q(cfg_q)
    );

    wu_tick_sel u_sel (
        .cfg(cfg_q), .hs_tick(hs_tick), .ls_tick(ls_tick), .tick(tick)
    );

    wu_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .clr(go),
        .en((state == WU_RUN) && tick), .cfg(cfg_q), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= WU_IDLE;
            done          <= 1'b0;
            release_pulse <= 1'b0;
        end else begin
            release_pulse <= go_zero || hit;
            if (go) begin
                state <= go_zero ? WU_IDLE : WU_RUN;
                done  <= go_zero;
            end else if (hit) begin
                state <= WU_IDLE;
                done  <= 1'b1;
            end
        end
    end

    always_comb busy = (state == WU_RUN);

    // R8: release lasts one cycle and coincides with completion status
    p_release_single_r8: assert property (@(posedge clk) disable iff (rst)
        release_pulse |=> !release_pulse);
    p_release_status_r8: assert property (@(posedge clk) disable iff (rst)
        release_pulse |-> (done && !busy));
    // R9: status flags exclusive, done held until a start
    p_flags_excl_r9: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !start_req) |=> done);
    // R4: zero code releases immediately without busy
    p_zero_code_r4: assert property (@(posedge clk) disable iff (rst)
        (start_req && !busy && len_code == 3'd0) |=> (!busy && release_pulse));
    // R6: start while busy does not clear the run
    p_busy_start_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && start_req && !hit) |=> busy);
endmodule

// File: tb/warmup_timer_test.sv
module warmup_timer_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       src_sel = 1'b0;
    logic [2:0] len_code = 3'd0;
    logic       start_wr = 1'b0;
    logic       wake_evt = 1'b0;
    logic       hs_tick = 1'b0;
    logic       ls_tick = 1'b0;
    logic       busy, done, release_pulse;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    warmup_timer uut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .len_code(len_code),
        .start_wr(start_wr), .wake_evt(wake_evt), .hs_tick(hs_tick),
        .ls_tick(ls_tick), .busy(busy), .done(done),
        .release_pulse(release_pulse)
    );

    function automatic int exp_ticks(bit sel, int code);
        if (code == 0) return 0;
        if (!sel) return 1 << (9 + code);
        if (code < 4) return 1 << (5 + code);
        return 1 << (11 + code);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            chk(1'b0, "watchdog", cyc, 190000);
            summary();
        end
    end

    // dens: selected source ticks with probability 1/(dens+1)
    // other: 0 never, 1 random, 2 always for the unselected source
    task automatic run(bit sel, int code, int dens, int other, bit perturb,
                       bit use_wake, string tag);
        int n = 0;
        int lim = exp_ticks(sel, code) * (dens + 1) * 4 + 200;
        bit got = 0;
        @(negedge clk);
        src_sel = sel; len_code = 3'(code);
        start_wr = !use_wake; wake_evt = use_wake;
        hs_tick = 0; ls_tick = 0;
        @(negedge clk);
        start_wr = 0; wake_evt = 0;
        if (code == 0) begin
            chk(release_pulse == 1, {tag, " R4 release"}, release_pulse, 1);
            chk(busy == 0, {tag, " R4 busy"}, busy, 0);
            chk(done == 1, {tag, " R4 done"}, done, 1);
            @(negedge clk);
            chk(release_pulse == 0, {tag, " R8 pulse end"}, release_pulse, 0);
            chk(done == 1, {tag, " R9 sticky"}, done, 1);
            return;
        end
        chk(busy == 1, {tag, " busy after start"}, busy, 1);
        chk(done == 0, {tag, " R9 done cleared"}, done, 0);
        for (int i = 0; i < lim; i++) begin
            bit s = (($urandom % (dens + 1)) == 0);
            bit o = (other == 2) ? 1'b1 : (other == 1) ? 1'($urandom % 2) : 1'b0;
            if (sel) begin ls_tick = s; hs_tick = o; end
            else     begin hs_tick = s; ls_tick = o; end
            if (perturb) begin
                src_sel  = 1'($urandom % 2);
                len_code = 3'($urandom % 8);
                start_wr = (($urandom % 4) == 0);
                wake_evt = (($urandom % 4) == 0);
            end
            @(negedge clk);
            n += int'(s);
            if (release_pulse) begin got = 1; break; end
            if (!busy) begin
                chk(1'b0, {tag, " busy dropped early"}, n, exp_ticks(sel, code));
                break;
            end
        end
        start_wr = 0; wake_evt = 0; hs_tick = 0; ls_tick = 0;
        chk(got && n == exp_ticks(sel, code), {tag, " tick count"}, n, exp_ticks(sel, code));
        chk(done == 1 && busy == 0, {tag, " R8 status at release"}, {done, busy}, 2);
        @(negedge clk);
        chk(release_pulse == 0, {tag, " R8 single cycle"}, release_pulse, 0);
        repeat (3) @(negedge clk);
        chk(done == 1, {tag, " R9 done held"}, done, 1);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(busy == 0 && done == 0 && release_pulse == 0, "R1 reset state",
            {busy, done, release_pulse}, 0);
        rst = 0;
        @(negedge clk);
        chk(busy == 0 && done == 0 && release_pulse == 0, "R1 after reset",
            {busy, done, release_pulse}, 0);

        run(0, 1, 0, 0, 0, 0, "R2 fast c1");
        run(0, 2, 1, 1, 0, 0, "R2 fast c2");
        run(0, 3, 1, 1, 0, 0, "R2 fast c3");
        run(0, 4, 0, 1, 0, 0, "R2 fast c4");
        run(1, 1, 0, 0, 0, 0, "R3 slow c1");
        run(1, 2, 2, 1, 0, 0, "R3 slow c2");
        run(1, 3, 1, 1, 0, 0, "R3 slow c3");
        run(0, 0, 0, 0, 0, 0, "R4 zero fast");
        run(1, 0, 0, 0, 0, 1, "R4 zero wake");
        run(1, 2, 1, 1, 0, 1, "R5 wake slow");
        run(0, 1, 1, 1, 0, 1, "R5 wake fast");
        run(1, 3, 1, 1, 1, 0, "R6 R7 perturb slow");
        run(0, 2, 1, 1, 1, 0, "R6 R7 perturb fast");
        run(1, 1, 3, 2, 0, 0, "R10 other always slow");
        run(0, 1, 3, 2, 1, 0, "R10 other always fast");
        for (int k = 0; k < 6; k++) begin
            bit sl = 1'($urandom % 2);
            int cd = 1 + int'($urandom % 2);
            run(sl, cd, int'($urandom % 3), 1, 1'($urandom % 2),
                1'($urandom % 2), "R2 R3 R6 random");
        end

        // Long slow wait: still busy well inside its 2^15 ticks
        @(negedge clk);
        src_sel = 1; len_code = 3'd4; start_wr = 1;
        @(negedge clk);
        start_wr = 0;
        for (int i = 0; i < 2000; i++) begin
            ls_tick = 1; hs_tick = 1;
            @(negedge clk);
        end
        chk(busy == 1 && done == 0, "R3 long code still busy", {busy, done}, 2);
        ls_tick = 0; hs_tick = 0;
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk(busy == 0 && done == 0 && release_pulse == 0, "R1 reset mid-run",
            {busy, done, release_pulse}, 0);
        summary();
    end
endmodule